// File: doc/BRIEF.md
# Memory-Mapped Latched Byte Port

This peripheral connects an 8-bit processor bus to a bank of eight indicator lamps, a bank of eight switches, a digital input byte and a four-channel motor control register. It watches a 16 KB window of the address space (top two address bits `01`, i.e. $4000–$7FFF). Inside that window it turns A13, A12 and the read/write flag into one of eight active-low select lines. A select goes low for as long as the bus strobe is active.

Each capture register samples on the rising edge of its select, which is the end of the access. A write to $4000–$4FFF loads the lamp register. The lamp port always shows the last byte written. A read of $4000–$4FFF has the switch register drive the data bus while the select is low. The same select's rising edge then captures the switches. A read therefore returns the switch value taken at the end of the previous read, one read stale. Reads of $7000–$7FFF return the digital input byte live. Writes to that range set the motor direction and enable nibbles. All other selects are only brought out to pins.

Top module: `latched_byte_port`

## Requirements
- R1: While reset is active and after it is released with no access, `led`, `motor_dir` and `motor_en` are 0, every `sel_n` bit is 1 and `bus_rdata_oe` is 0.
- R2: With `bus_strobe`=1 and `bus_addr[15:14]`=2'b01, exactly one `sel_n` bit is 0. Its index is {A13, A12, rw}, with `bus_rw`=1 meaning read.
- R3: With `bus_strobe`=0, or with `bus_addr[15:14]` not 2'b01, all `sel_n` bits are 1 and the bus is not driven.
- R4: A write to $4000–$4FFF (select 0) sets `led` to the written byte on the first clock edge after the select returns high. `led` holds that byte until the next such write.
- R5: During a read of $4000–$4FFF (select 1), the block drives the bus with the switch byte captured at the end of the previous such read. The first such read after reset returns 0x00.
- R6: During a read of $7000–$7FFF (select 7), the block drives the bus with the present value of `din`.
- R7: A write to $7000–$7FFF (select 6) sets `motor_dir` to data[3:0] and `motor_en` to data[7:4] once the select returns high.
- R8: `bus_rdata_oe` is 1 only during reads that assert select 1 or select 7. It is never 1 during writes or during reads of $5000–$6FFF.
- R9: Writes to $5000–$6FFF leave `led`, `motor_dir` and `motor_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Processor address |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_strobe | input | 1 | Bus cycle active |
| bus_wdata | input | 8 | Data from the bus for writes |
| bus_rdata | output | 8 | Data the block places on the bus |
| bus_rdata_oe | output | 1 | Drive enable for `bus_rdata` |
| sel_n | output | 8 | Active-low decoded selects |
| led | output | 8 | Lamp register output |
| sw | input | 8 | Switch inputs |
| din | input | 8 | Digital input byte |
| motor_dir | output | 4 | Motor direction bits |
| motor_en | output | 4 | Motor enable bits (1 = on) |

## Verification
The bench uses the default widths: 16 address bits, 8 data bits and a 3-bit select index. With these widths all eight select codes can be reached from ordinary bus addresses. Accesses to the upper and lower halves of the space exercise the window decode.

The bench models the data bus as a real tri-state net shared by both drivers. Any overlap between the two drivers shows up as contention. The one-read staleness is made visible by changing the switches between consecutive reads.

// File: rtl/latched_byte_port_pkg.sv
package latched_byte_port_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned NUM_SEL  = 1 << IDX_W;
  localparam int unsigned NIB_W    = DATA_W / 2;
  localparam logic [1:0]  WIN_TAG  = 2'b01;

  // Select indices: {A13, A12, rw}
  localparam int unsigned SEL_LED_WR   = 0;
  localparam int unsigned SEL_SW_RD    = 1;
  localparam int unsigned SEL_MOTOR_WR = 6;
  localparam int unsigned SEL_DIN_RD   = 7;
endpackage

// File: rtl/lbp_rst_sync.sv
module lbp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lbp_sel_decoder.sv
module lbp_sel_decoder #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned IDX_W   = 3,
  parameter logic [1:0]  WIN_TAG = 2'b01,
  localparam int unsigned NUM_SEL = 1 << IDX_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rw,
  input  logic               strobe,
  output logic [NUM_SEL-1:0] sel_n
);
  logic             in_window;
  logic [IDX_W-1:0] idx;

  assign in_window = strobe && (addr[ADDR_W-1 -: 2] == WIN_TAG);
  assign idx       = {addr[ADDR_W-3 -: (IDX_W-1)], rw};

  always_comb begin
    sel_n = '1;
    for (int i = 0; i < NUM_SEL; i++) begin
      if (in_window && (idx == IDX_W'(i))) sel_n[i] = 1'b0;
    end
  end
endmodule

// File: rtl/lbp_edge_reg.sv
module lbp_edge_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic             sel_q;
  logic [WIDTH-1:0] sample_q, sample_d;
  logic [WIDTH-1:0] q_q, q_d;
  logic             sample_en, commit_en;

  assign sample_en = !sel_n;
  assign commit_en = sel_n && !sel_q;

  always_comb begin
    sample_d = sample_q;
    if (sample_en) sample_d = d;
    q_d = q_q;
    if (commit_en) q_d = sample_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b1;
      sample_q <= '0;
      q_q      <= '0;
    end else begin
      sel_q    <= sel_n;
      sample_q <= sample_d;
      q_q      <= q_d;
    end
  end

  assign q = q_q;
endmodule

// File: rtl/lbp_read_mux.sv
module lbp_read_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              sw_sel_n,
  input  logic              din_sel_n,
  input  logic [DATA_W-1:0] sw_held,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  always_comb begin
    rdata_oe = 1'b0;
    rdata    = '0;
    if (!sw_sel_n) begin
      rdata_oe = 1'b1;
      rdata    = sw_held;
    end else if (!din_sel_n) begin
      rdata_oe = 1'b1;
      rdata    = din;
    end
  end
endmodule

// File: rtl/latched_byte_port.sv
module latched_byte_port
  import latched_byte_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rw,
  input  logic              bus_strobe,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  output logic [NUM_SEL-1:0] sel_n,
  output logic [DATA_W-1:0] led,
  input  logic [DATA_W-1:0] sw,
  input  logic [DATA_W-1:0] din,
  output logic [NIB_W-1:0]  motor_dir,
  output logic [NIB_W-1:0]  motor_en
);
  logic              rst_n_sync;
  logic [DATA_W-1:0] sw_held;
  logic [DATA_W-1:0] motor_q;

  lbp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_sync)
  );

  lbp_sel_decoder #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WIN_TAG(WIN_TAG)) u_dec (
    .addr(bus_addr), .rw(bus_rw), .strobe(bus_strobe), .sel_n(sel_n)
  );

  lbp_edge_reg #(.WIDTH(DATA_W)) u_led_reg (
    .clk(clk), .rst_n(rst_n_sync), .sel_n(sel_n[SEL_LED_WR]),
    .d(bus_wdata), .q(led)
  );

  lbp_edge_reg #(.WIDTH(DATA_W)) u_sw_reg (
    .clk(clk), .rst_n(rst_n_sync), .sel_n(sel_n[SEL_SW_RD]),
    .d(sw), .q(sw_held)
  );

  lbp_edge_reg #(.WIDTH(DATA_W)) u_motor_reg (
    .clk(clk), .rst_n(rst_n_sync), .sel_n(sel_n[SEL_MOTOR_WR]),
    .d(bus_wdata), .q(motor_q)
  );

  lbp_read_mux #(.DATA_W(DATA_W)) u_rmux (
    .sw_sel_n(sel_n[SEL_SW_RD]), .din_sel_n(sel_n[SEL_DIN_RD]),
    .sw_held(sw_held), .din(din),
    .rdata(bus_rdata), .rdata_oe(bus_rdata_oe)
  );

  assign motor_dir = motor_q[NIB_W-1:0];
  assign motor_en  = motor_q[DATA_W-1:NIB_W];
endmodule

// File: rtl/latched_byte_port_checker.sv
module latched_byte_port_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe,
  input logic       rw,
  input logic [7:0] sel_n,
  input logic       oe,
  input logic [7:0] led,
  input logic [3:0] motor_dir,
  input logic [3:0] motor_en
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sel_n) <= 1); // R2

  AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> (sel_n == 8'hFF && !oe)); // R3

  AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sel_n[0]) |=> $stable(led)); // R4

  AST_MOTOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sel_n[6]) |=> ($stable(motor_dir) && $stable(motor_en))); // R7

  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (strobe && rw && (!sel_n[1] || !sel_n[7]))); // R8
endmodule

bind latched_byte_port latched_byte_port_checker u_chk (
  .clk(clk), .rst_n(rst_n_sync), .strobe(bus_strobe), .rw(bus_rw),
  .sel_n(sel_n), .oe(bus_rdata_oe), .led(led),
  .motor_dir(motor_dir), .motor_en(motor_en)
);

// File: tb/latched_byte_port_tb.sv
`timescale 1ns/1ps
module latched_byte_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        rw, strobe, cpu_drv;
  logic [7:0]  cpu_data, sw, din;
  wire  [7:0]  dbus;
  logic [7:0]  rdata, sel_n, led;
  logic        oe;
  logic [3:0]  motor_dir, motor_en;

  int checks = 0;
  int errors = 0;
  int bad_oe = 0;
  int clash  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  assign dbus = oe ? rdata : 8'hzz;
  assign dbus = cpu_drv ? cpu_data : 8'hzz;

  latched_byte_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rw(rw),
    .bus_strobe(strobe), .bus_wdata(dbus), .bus_rdata(rdata),
    .bus_rdata_oe(oe), .sel_n(sel_n), .led(led), .sw(sw), .din(din),
    .motor_dir(motor_dir), .motor_en(motor_en)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sel(input logic [15:0] a, input logic rd, input logic stb);
    if (stb && a[15:14] == 2'b01) return ~(8'h01 << {a[13], a[12], rd});
    return 8'hFF;
  endfunction

  task automatic bus_op(input logic [15:0] a, input logic rd, input logic [7:0] wd,
                        input logic stb, input string req);
    @(negedge clk);
    addr = a; rw = rd; cpu_data = wd; strobe = stb;
    cpu_drv = stb && !rd;
    @(negedge clk);
    chk(sel_n, exp_sel(a, rd, stb), (stb && a[15:14] == 2'b01) ? "R2" : "R3");
    repeat (2) @(negedge clk);
    strobe = 1'b0; cpu_drv = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_expect(input logic [15:0] a, input logic [7:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    bus_op(a, 1'b1, 8'h00, 1'b1, req);
  endtask

  // Monitor / scoreboard
  initial begin
    logic [7:0] last_val;
    logic       prev_oe;
    last_val = '0;
    prev_oe  = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      if (oe && cpu_drv) clash++;
      if (oe && !(strobe && rw && addr[15:14] == 2'b01 &&
                  (addr[13:12] == 2'b00 || addr[13:12] == 2'b11))) bad_oe++;
      if (oe) last_val = dbus;
      if (prev_oe && !oe) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8: actual unexpected read %h expected none", last_val);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(last_val, e, t);
        end
      end
      prev_oe = oe;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; rw = 1'b0; strobe = 1'b0; cpu_drv = 1'b0;
    cpu_data = '0; sw = 8'h00; din = 8'h00;
    repeat (4) @(negedge clk);
    chk(sel_n, 8'hFF, "R1");
    chk({7'd0, oe}, 8'h00, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(led, 8'h00, "R1");
    chk({motor_en, motor_dir}, 8'h00, "R1");

    // R4 lamp writes
    bus_op(16'h4000, 1'b0, 8'hA5, 1'b1, "R4");
    chk(led, 8'hA5, "R4");
    bus_op(16'h4123, 1'b0, 8'h3C, 1'b1, "R4");
    chk(led, 8'h3C, "R4");

    // R5 stale switch reads
    sw = 8'h5A;
    rd_expect(16'h4000, 8'h00, "R5");
    sw = 8'h81;
    rd_expect(16'h4FFF, 8'h5A, "R5");
    sw = 8'h24;
    rd_expect(16'h4800, 8'h81, "R5");

    // R6 live digital input
    din = 8'h77;
    rd_expect(16'h7000, 8'h77, "R6");
    din = 8'h12;
    rd_expect(16'h7ABC, 8'h12, "R6");

    // R7 motor register
    bus_op(16'h7000, 1'b0, 8'hC3, 1'b1, "R7");
    chk({4'd0, motor_dir}, 8'h03, "R7");
    chk({4'd0, motor_en}, 8'h0C, "R7");

    // R8 reads in other ranges, R9 writes elsewhere
    bus_op(16'h5000, 1'b1, 8'h00, 1'b1, "R8");
    bus_op(16'h6FFF, 1'b1, 8'h00, 1'b1, "R8");
    bus_op(16'h5000, 1'b0, 8'hFF, 1'b1, "R9");
    bus_op(16'h6004, 1'b0, 8'hEE, 1'b1, "R9");
    chk(led, 8'h3C, "R9");
    chk({motor_en, motor_dir}, 8'hC3, "R9");

    // R3 outside window / no strobe
    bus_op(16'h0000, 1'b0, 8'h11, 1'b1, "R3");
    bus_op(16'h8000, 1'b1, 8'h00, 1'b1, "R3");
    bus_op(16'hC000, 1'b0, 8'h22, 1'b1, "R3");
    bus_op(16'h4000, 1'b0, 8'h99, 1'b0, "R3");
    chk(led, 8'h3C, "R3");

    repeat (4) @(negedge clk);
    chk(8'(exp_q.size()), 8'h00, "R5");
    chk(8'(bad_oe), 8'h00, "R8");
    chk(8'(clash), 8'h00, "R8");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule